// File: doc/BRIEF.md
# Prefix Relocation and Storage Key Unit

This block sits between a processor's address translation and main storage. It takes a real address and turns it into an absolute address by exchanging two 8 KB windows: real addresses in the lowest 8 KB go to the area the prefix register points at, and real addresses inside that area go to absolute page zero. All other addresses pass through unchanged. An access that starts inside either exchanged window has its length cut so that it stops at the end of that window. The caller can then split a longer transfer into pieces.

For every accepted access, the block records usage in an internal array that holds two bits per 4 KB page of configured storage. A reference bit is set on every access. A change bit is set on stores. An absolute address beyond configured storage raises an addressing exception and leaves the array untouched. The prefix register accepts only 8 KB aligned values. A read-out port returns the two bits of any page.

Top module: `pfx_storage_unit`

## Requirements
- R1: A real address below 8192 yields absolute address = real address + prefix. This case has priority when the prefix is zero.
- R2: A real address A with prefix <= A < prefix + 8192 (and A >= 8192) yields absolute address = A - prefix.
- R3: Every other real address yields an absolute address equal to the real address.
- R4: In the R1 and R2 cases, the returned length is min(length, 8192 - offset), where offset is the address position inside its 8 KB window. In the R3 case, the length is returned unchanged.
- R5: An accepted access with no exception sets bit 0 (reference) of the page at absolute address >> 12. Kind 2'b01 (store) also sets bit 1 (change). Kinds 2'b00 (read), 2'b10 (fetch) and 2'b11 set only the reference bit. The update shows on rd_key in the cycle after the request.
- R6: An absolute address >= MEM_PAGES * 4096 sets rsp_exc. That access changes no key bit.
- R7: pfx_load stores pfx_in with its low 13 bits forced to zero. The new value is used from the next cycle on. Reset sets the prefix to zero.
- R8: Reset or key_clr zeroes every reference and change bit. A key_clr in the same cycle as a request wins over that request's update.
- R9: rsp_valid is high in exactly the cycle after a cycle with req_valid high. In that cycle rsp_abs, rsp_len and rsp_exc give the result for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_load | input | 1 | Load the prefix register |
| pfx_in | input | ADDR_W | New prefix value |
| key_clr | input | 1 | Clear all key bits |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Real address |
| req_len | input | LEN_W | Access length in bytes |
| req_kind | input | 2 | 00 read, 01 store, 10 fetch, 11 treated as read |
| rsp_valid | output | 1 | Result strobe |
| rsp_abs | output | ADDR_W | Absolute address |
| rsp_len | output | LEN_W | Clipped length |
| rsp_exc | output | 1 | Addressing exception |
| rd_page | input | PG_W | Page index for key read-out |
| rd_key | output | 2 | {change, reference} of rd_page |

## Verification
Real addresses are swept across the whole address space in 256-byte steps under four prefixes. A zero prefix makes the two windows coincide and tests the R1 priority. A mid-storage prefix separates the add path from the subtract path and from pass-through. A prefix at the top of storage puts the relocated low window right at the storage boundary. A prefix beyond storage makes low addresses fault while the prefix area itself still maps to page zero. The lengths vary with the address, so each window has accesses both shorter than and longer than the distance to its end. Exact-fit lengths at a window end are covered by directed cases. After each sweep, every page's key bits are compared against a bench model that mixes read, store and fetch kinds. This shows whether change bits follow stores only and whether faulting accesses leave the array untouched.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int WIN_SHIFT  = 13;
  localparam int PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_STORE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic lo_win;
    logic pfx_win;
    logic exc;
  } reloc_flags_t;
endpackage

// File: rtl/pfx_relocate.sv
module pfx_relocate
  import pfx_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int LEN_W     = 14,
  parameter int MEM_PAGES = 64,
  localparam int PG_W     = (MEM_PAGES > 1) ? $clog2(MEM_PAGES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] pfx,
  output logic [ADDR_W-1:0] abs_addr,
  output logic [LEN_W-1:0]  len_out,
  output reloc_flags_t      flags,
  output logic [PG_W-1:0]   page
);
  localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(1 << WIN_SHIFT);
  localparam logic [ADDR_W:0]   MEM_LIMIT = (ADDR_W+1)'(MEM_PAGES) << PAGE_SHIFT;

  function automatic logic [LEN_W-1:0] clip_len(input logic [LEN_W-1:0] l,
                                                input logic [WIN_SHIFT-1:0] off);
    logic [LEN_W-1:0] room;
    room = LEN_W'(1 << WIN_SHIFT) - LEN_W'(off);
    return (l > room) ? room : l;
  endfunction

  logic [ADDR_W-1:0] diff;
  logic              in_lo, in_pfx;

  always_comb begin
    diff   = addr - pfx;
    in_lo  = addr < WIN_BYTES;
    in_pfx = !in_lo && (addr >= pfx) && (diff < WIN_BYTES);
    if (in_lo) begin
      abs_addr = addr + pfx;
      len_out  = clip_len(len, addr[WIN_SHIFT-1:0]);
    end else if (in_pfx) begin
      abs_addr = diff;
      len_out  = clip_len(len, diff[WIN_SHIFT-1:0]);
    end else begin
      abs_addr = addr;
      len_out  = len;
    end
    flags.lo_win  = in_lo;
    flags.pfx_win = in_pfx;
    flags.exc     = {1'b0, abs_addr} >= MEM_LIMIT;
    page          = abs_addr[PAGE_SHIFT +: PG_W];
  end
endmodule

// File: rtl/pfx_keyarray.sv
module pfx_keyarray #(
  parameter int MEM_PAGES = 64,
  localparam int PG_W     = (MEM_PAGES > 1) ? $clog2(MEM_PAGES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 upd_en,
  input  logic [PG_W-1:0]      upd_page,
  input  logic                 upd_store,
  input  logic [PG_W-1:0]      rd_page,
  output logic [1:0]           rd_key,
  output logic [MEM_PAGES-1:0] ref_vec,
  output logic [MEM_PAGES-1:0] chg_vec
);
  for (genvar g = 0; g < MEM_PAGES; g++) begin : g_page
    logic hit;
    assign hit = upd_en && (upd_page == PG_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        ref_vec[g] <= 1'b0;
        chg_vec[g] <= 1'b0;
      end else if (hit) begin
        ref_vec[g] <= 1'b1;
        if (upd_store) chg_vec[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    if (32'(rd_page) < MEM_PAGES) rd_key = {chg_vec[rd_page], ref_vec[rd_page]};
    else                          rd_key = 2'b00;
  end

  // R5: a change bit is never set without its reference bit
  a_r5_chg_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_vec & ~ref_vec) == '0);
  // R8: without a clear, key bits only accumulate
  a_r8_keys_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (((ref_vec & $past(ref_vec)) == $past(ref_vec)) &&
                     ((chg_vec & $past(chg_vec)) == $past(chg_vec))));
  // R8: a clear empties the array
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (ref_vec == '0 && chg_vec == '0));
endmodule

// File: rtl/pfx_storage_unit.sv
module pfx_storage_unit
  import pfx_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int LEN_W     = 14,
  parameter int MEM_PAGES = 64,
  localparam int PG_W     = (MEM_PAGES > 1) ? $clog2(MEM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_load,
  input  logic [ADDR_W-1:0] pfx_in,
  input  logic              key_clr,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_abs,
  output logic [LEN_W-1:0]  rsp_len,
  output logic              rsp_exc,
  input  logic [PG_W-1:0]   rd_page,
  output logic [1:0]        rd_key
);
  logic [ADDR_W-1:0]    pfx_q;
  logic [ADDR_W-1:0]    abs_c;
  logic [LEN_W-1:0]     len_c;
  reloc_flags_t         flg_c;
  logic [PG_W-1:0]      page_c;
  logic                 key_upd;
  logic                 is_store;
  logic [MEM_PAGES-1:0] ref_vec, chg_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)        pfx_q <= '0;
    else if (pfx_load) pfx_q <= {pfx_in[ADDR_W-1:WIN_SHIFT], {WIN_SHIFT{1'b0}}};
  end

  pfx_relocate #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_PAGES(MEM_PAGES)) u_reloc (
    .addr(req_addr), .len(req_len), .pfx(pfx_q),
    .abs_addr(abs_c), .len_out(len_c), .flags(flg_c), .page(page_c)
  );

  assign is_store = acc_kind_e'(req_kind) == KIND_STORE;
  assign key_upd  = req_valid && !flg_c.exc;

  pfx_keyarray #(.MEM_PAGES(MEM_PAGES)) u_keys (
    .clk(clk), .rst_n(rst_n), .clr(key_clr),
    .upd_en(key_upd), .upd_page(page_c), .upd_store(is_store),
    .rd_page(rd_page), .rd_key(rd_key), .ref_vec(ref_vec), .chg_vec(chg_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_abs   <= '0;
      rsp_len   <= '0;
      rsp_exc   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_abs <= abs_c;
        rsp_len <= len_c;
        rsp_exc <= flg_c.exc;
      end
    end
  end

  // R7: prefix is always 8 KB aligned
  a_r7_prefix_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_q[WIN_SHIFT-1:0] == '0);
  // R4: clipping never lengthens an access
  a_r4_len_not_grown: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_len <= $past(req_len));
  // R6: a faulting access leaves all key bits as they were
  a_r6_exc_keys_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc && !$past(key_clr)) |->
      (ref_vec == $past(ref_vec) && chg_vec == $past(chg_vec)));
  // R2: the prefix area always lands in absolute page zero's window
  a_r2_pfx_to_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(flg_c.pfx_win)) |-> rsp_abs < ADDR_W'(1 << WIN_SHIFT));
endmodule

// File: tb/test_pfx_storage_unit.sv
`timescale 1ns/1ps
module test_pfx_storage_unit;
  localparam int ADDR_W = 20, LEN_W = 14, MEM_PAGES = 64, PG_W = 6;
  localparam int MEM_BYTES = MEM_PAGES * 4096;

  logic clk = 0, rst_n = 0, pfx_load = 0, key_clr = 0, req_valid = 0;
  logic [ADDR_W-1:0] pfx_in = '0, req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [1:0] req_kind = '0;
  logic rsp_valid, rsp_exc;
  logic [ADDR_W-1:0] rsp_abs;
  logic [LEN_W-1:0] rsp_len;
  logic [PG_W-1:0] rd_page = '0;
  logic [1:0] rd_key;

  int n_tests = 0, n_fail = 0;
  int cur_pfx = 0;
  bit m_ref [MEM_PAGES];
  bit m_chg [MEM_PAGES];

  always #4 clk = ~clk;

  pfx_storage_unit i_pfx_storage_unit (.*);

  initial begin
    #1_500_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < MEM_PAGES; i++) begin m_ref[i] = 0; m_chg[i] = 0; end
  endtask

  task automatic load_pfx(input int v);
    @(negedge clk); pfx_load = 1; pfx_in = ADDR_W'(v);
    @(negedge clk); pfx_load = 0;
    cur_pfx = v & ~32'h1FFF;
  endtask

  // Bench-side restatement of R1..R4, R6.
  task automatic do_req(input int a, input int l, input int k, input bit clr, input bit quiet);
    int ea, el, off; bit in_win, ee;
    in_win = 0;
    if (a < 8192) begin ea = a + cur_pfx; off = a; in_win = 1; end
    else if (a >= cur_pfx && a < cur_pfx + 8192) begin ea = a - cur_pfx; off = a - cur_pfx; in_win = 1; end
    else begin ea = a; off = 0; end
    el = (in_win && l > 8192 - off) ? 8192 - off : l;
    ee = ea >= MEM_BYTES;
    @(negedge clk);
    req_valid = 1; req_addr = ADDR_W'(a); req_len = LEN_W'(l); req_kind = 2'(k); key_clr = clr;
    @(negedge clk);
    req_valid = 0; key_clr = 0;
    if (!quiet || rsp_abs != ADDR_W'(ea) || rsp_len != LEN_W'(el) || rsp_exc != ee || !rsp_valid) begin
      chk("R9 rsp_valid", rsp_valid, 1);
      chk(a < 8192 ? "R1 abs" : (in_win ? "R2 abs" : "R3 abs"), rsp_abs, ea);
      chk("R4 len", rsp_len, el);
      chk("R6 exc", rsp_exc, ee);
    end else n_tests++;
    if (clr) model_clear();
    else if (!ee) begin
      m_ref[ea / 4096] = 1;
      if (k == 1) m_chg[ea / 4096] = 1;
    end
  endtask

  task automatic check_keys(input string req);
    @(negedge clk);
    chk("R9 rsp_valid idle", rsp_valid, 0);
    for (int p = 0; p < MEM_PAGES; p++) begin
      rd_page = PG_W'(p);
      #1;
      chk(req, rd_key, {m_chg[p], m_ref[p]});
    end
  endtask

  initial begin
    int pf [4] = '{0, 32'h6000, 32'h3E000, 32'hF2000};
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset rsp_valid", rsp_valid, 0);
    check_keys("R8 reset keys");
    do_req(32'h100, 16, 0, 0, 0);               // R7 reset prefix zero -> abs = addr
    check_keys("R5 first read");

    foreach (pf[i]) begin
      load_pfx(pf[i] | 32'h1ABC);               // R7 low bits dropped
      do_req(0, 1, 0, 0, 0);
      chk("R7 prefix aligned", rsp_abs, pf[i]);
      do_req(0, 1, 0, 1, 0);                    // R8 clear wins over update
      check_keys("R8 clear with request");
      for (int a = 0; a < (1 << ADDR_W); a += 256) begin
        do_req(a, ((a >> 4) * 37) % 16384, (a >> 8) % 4, 0, 1);
      end
      check_keys("R5 R6 key model");
    end

    load_pfx(32'h6000);
    do_req(32'h1F00, 256, 1, 0, 0);   // R4 exact fit, not clipped
    do_req(32'h1F00, 257, 1, 0, 0);   // R4 clipped to 256
    do_req(32'h7FFF, 9000, 2, 0, 0);  // R2 last byte, length 1
    do_req(32'h8000, 9000, 0, 0, 0);  // R3 just past prefix area
    do_req(32'h5FFF, 9000, 0, 0, 0);  // R3 just before prefix area
    do_req(MEM_BYTES - 1, 5, 1, 0, 0);// R6 last valid byte
    do_req(MEM_BYTES, 5, 1, 0, 0);    // R6 first invalid byte
    check_keys("R5 directed keys");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule